// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Frame Sequencer

This block is the device-side front end of a serial NOR flash. It decides how each chip-select frame is parsed. A frame either starts with an 8-bit opcode and then carries an address, or it carries a bare 24-bit address with no opcode, which is execute-in-place (XIP) operation. The block samples the DQ lines on each rising SCK edge while CS# is low. It follows single, dual or quad line width, fetches bytes through a simple read port and shifts them out most significant bit first.

XIP is entered in one of three ways. A volatile arm bit can be cleared, after which a fast read can confirm XIP. A strap input arms every fast read. A non-volatile width field starts the device in XIP directly after power-on reset. The confirmation bit is DQ0 during the first dummy clock of a read. A 0 on an armed read keeps the next frame address-only. A 1 returns the device to opcode parsing. A rescue pattern on DQ0 at the start of a frame forces standard mode from any state.

Top module: `xip_frame_seq`

## Requirements
- R1: On power-on reset (`rstN` low), `xipActive` and `xipWidth` are loaded from `cfgNvXip`. The values 0, 1 and 2 select XIP at single, dual or quad width, and `xipWidth` reports codes 0, 1 and 2 for those widths. The values 3 to 7 leave the device in standard mode.
- R2: In standard mode a frame's first 8 clocks carry an opcode on DQ0, MSB first. Opcode 0x0B selects a single-line read, 0xBB a dual-line read and 0xEB a quad-line read. The 24-bit address follows MSB first: on DQ0 for single, on DQ1:DQ0 for dual (DQ1 holds the higher bit) and on DQ3:DQ0 for quad.
- R3: Any other opcode makes the rest of the frame ignored. `dqOe` stays 0 and the XIP state is unchanged.
- R4: After the address come DUMMY_CYC dummy clocks. The rising edge that ends the last dummy clock loads the byte at `rdAddr` (equal to the frame address). From then on `dqOut` presents that byte MSB first, one chunk per clock: DQ1 for single, DQ1:DQ0 for dual, DQ3:DQ0 for quad. The following bytes come from increasing addresses.
- R5: `dqOe` is 4'b0010, 4'b0011 or 4'b1111 for single, dual or quad data clocks. It is 0 outside the data phase, including from the first clock after CS# rises.
- R6: If DQ0 is 0 in the first dummy clock and the read is armed, `xipActive` becomes 1 after that clock, and `xipWidth` takes the frame's width. A read is armed when `cfgVolXipN` is 0, or `cfgAlwaysArm` is 1, or the frame is already an XIP frame.
- R7: If DQ0 is 1 in the first dummy clock, `xipActive` becomes 0.
- R8: If DQ0 is 0 in the first dummy clock and the read is not armed, the device stays in standard mode.
- R9: While `xipActive` is 1, a frame has no opcode. Its first clocks carry the 24-bit address at the width in `xipWidth`, and dummy and data clocks follow as in R4.
- R10: If DQ0 is high on each of the first RESCUE_LEN clocks of a frame, `xipActive` drops after that clock and the rest of the frame is ignored (`dqOe` stays 0).
- R11: If CS# rises before the address is complete, the frame is dropped without changing `xipActive` or `xipWidth`.
- R12: `xipActive` changes only on a clock edge at which CS# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edges sample DQ and CS# |
| rstN | input | 1 | Synchronous power-on reset, active low |
| csN | input | 1 | Chip select, active low; high ends a frame |
| dqIn | input | 4 | Input side of DQ3..DQ0 |
| dqOut | output | 4 | Output side of DQ3..DQ0 |
| dqOe | output | 4 | Per-line output enable |
| cfgVolXipN | input | 1 | Volatile XIP arm bit, active low |
| cfgAlwaysArm | input | 1 | Strap: every fast read is armed for XIP |
| cfgNvXip | input | 3 | Non-volatile boot XIP field, sampled in reset |
| rdAddr | output | ADDR_W | Byte address of the read port |
| rdData | input | 8 | Byte returned by the array for `rdAddr` in the same cycle |
| xipActive | output | 1 | Next frame is parsed as address-only |
| xipWidth | output | 2 | Line width of XIP frames: 0 single, 1 dual, 2 quad |

## Verification
The XIP state is due one rising edge after the first dummy clock, so the bench checks it at a falling edge once CS# is high, and again two clocks later to confirm it holds. The first read chunk is due after the edge that ends the last dummy clock, and each later chunk one clock after the one before. The bench drives each data clock on a falling edge and compares `dqOut` and `dqOe` at that same falling edge, before the next rising edge shifts them. Output enables must be off at the first falling edge after CS# rises, and the bench checks them there.

// File: rtl/xipseq_pkg.sv
package xipseq_pkg;

  typedef enum logic [1:0] {
    W1 = 2'd0,
    W2 = 2'd1,
    W4 = 2'd2
  } busWidthT;

  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } phaseT;

  // control -> datapath strobes
  typedef struct packed {
    logic     addrShift;
    logic     byteLoad;
    logic     dataShift;
    logic     drive;
    busWidthT width;
  } strobeT;

  localparam logic [7:0] OPC_READ1 = 8'h0B;
  localparam logic [7:0] OPC_READ2 = 8'hBB;
  localparam logic [7:0] OPC_READ4 = 8'hEB;

endpackage

// File: rtl/xipseq_ctrl.sv
module xipseq_ctrl
  import xipseq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CYC  = 8,
  parameter int RESCUE_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       dq0,
  input  logic       cfgVolXipN,
  input  logic       cfgAlwaysArm,
  input  logic [2:0] cfgNvXip,
  output strobeT     strobe,
  output logic       xipActive,
  output busWidthT   xipWidth
);

  localparam int MAXC  = (ADDR_W > DUMMY_CYC) ? ADDR_W : DUMMY_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int RUN_W = $clog2(RESCUE_LEN + 1);

  phaseT            phase;
  busWidthT         width;
  logic [CNT_W-1:0] cnt;
  logic [6:0]       opcSh;
  logic [RUN_W-1:0] runCnt;
  logic             runLive;

  logic             nvValid;
  busWidthT         nvWidth;
  logic [CNT_W-1:0] addrLast;
  logic [CNT_W-1:0] byteLast;
  logic [7:0]       opcFull;
  logic             rescueHit;
  logic             armed;
  logic             dummyEnd;
  logic             byteEnd;

  assign nvValid = (cfgNvXip < 3'd3);
  assign nvWidth = nvValid ? busWidthT'(cfgNvXip[1:0]) : W1;
  assign opcFull = {opcSh, dq0};
  assign armed   = xipActive || !cfgVolXipN || cfgAlwaysArm;

  always_comb begin
    case (width)
      W2:      begin addrLast = CNT_W'(ADDR_W / 2 - 1); byteLast = CNT_W'(3); end
      W4:      begin addrLast = CNT_W'(ADDR_W / 4 - 1); byteLast = CNT_W'(1); end
      default: begin addrLast = CNT_W'(ADDR_W - 1);     byteLast = CNT_W'(7); end
    endcase
  end

  assign rescueHit = !csN && runLive && dq0 && (runCnt == RUN_W'(RESCUE_LEN - 1));
  assign dummyEnd  = (phase == PH_DUMMY) && (cnt == CNT_W'(DUMMY_CYC - 1));
  assign byteEnd   = (phase == PH_DATA) && (cnt == byteLast);

  always_comb begin
    strobe.addrShift = !csN && !rescueHit && (phase == PH_ADDR);
    strobe.byteLoad  = !csN && !rescueHit && (dummyEnd || byteEnd);
    strobe.dataShift = !csN && !rescueHit && (phase == PH_DATA) && !byteEnd;
    strobe.drive     = (phase == PH_DATA);
    strobe.width     = width;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xipActive <= nvValid;
      xipWidth  <= nvWidth;
      phase     <= nvValid ? PH_ADDR : PH_OPC;
      width     <= nvWidth;
      cnt       <= '0;
      opcSh     <= '0;
      runCnt    <= '0;
      runLive   <= 1'b1;
    end else if (csN) begin
      phase   <= xipActive ? PH_ADDR : PH_OPC;
      width   <= xipActive ? xipWidth : W1;
      cnt     <= '0;
      runCnt  <= '0;
      runLive <= 1'b1;
    end else begin
      if (runLive) begin
        if (dq0) runCnt <= runCnt + 1'b1;
        else     runLive <= 1'b0;
      end
      if (rescueHit) begin
        xipActive <= 1'b0;
        phase     <= PH_SKIP;
        runLive   <= 1'b0;
      end else begin
        case (phase)
          PH_OPC: begin
            opcSh <= {opcSh[5:0], dq0};
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              case (opcFull)
                OPC_READ1: begin width <= W1; phase <= PH_ADDR; end
                OPC_READ2: begin width <= W2; phase <= PH_ADDR; end
                OPC_READ4: begin width <= W4; phase <= PH_ADDR; end
                default:   phase <= PH_SKIP;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (cnt == addrLast) begin
              cnt   <= '0;
              phase <= PH_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == '0) begin
              if (dq0) begin
                xipActive <= 1'b0;
              end else if (armed) begin
                xipActive <= 1'b1;
                xipWidth  <= width;
              end
            end
            if (dummyEnd) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (byteEnd) cnt <= '0;
            else         cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/xipseq_dpath.sv
module xipseq_dpath
  import xipseq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        dqIn,
  input  strobeT            strobe,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [3:0]        dqOut,
  output logic [3:0]        dqOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataSh;

  assign rdAddr = addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataSh  <= '0;
    end else begin
      if (strobe.addrShift) begin
        case (strobe.width)
          W2:      addrReg <= {addrReg[ADDR_W-3:0], dqIn[1:0]};
          W4:      addrReg <= {addrReg[ADDR_W-5:0], dqIn[3:0]};
          default: addrReg <= {addrReg[ADDR_W-2:0], dqIn[0]};
        endcase
      end else if (strobe.byteLoad) begin
        dataSh  <= rdData;
        addrReg <= addrReg + 1'b1;
      end
      if (strobe.dataShift) begin
        case (strobe.width)
          W2:      dataSh <= {dataSh[5:0], 2'b00};
          W4:      dataSh <= {dataSh[3:0], 4'b0000};
          default: dataSh <= {dataSh[6:0], 1'b0};
        endcase
      end
    end
  end

  always_comb begin
    dqOut = 4'b0000;
    dqOe  = 4'b0000;
    if (strobe.drive) begin
      case (strobe.width)
        W2:      begin dqOut = {2'b00, dataSh[7:6]};      dqOe = 4'b0011; end
        W4:      begin dqOut = dataSh[7:4];               dqOe = 4'b1111; end
        default: begin dqOut = {2'b00, dataSh[7], 1'b0};  dqOe = 4'b0010; end
      endcase
    end
  end

endmodule

// File: rtl/xip_frame_seq.sv
module xip_frame_seq
  import xipseq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DUMMY_CYC  = 8,
  parameter int RESCUE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [3:0]        dqIn,
  output logic [3:0]        dqOut,
  output logic [3:0]        dqOe,
  input  logic              cfgVolXipN,
  input  logic              cfgAlwaysArm,
  input  logic [2:0]        cfgNvXip,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              xipActive,
  output logic [1:0]        xipWidth
);

  strobeT   strobe;
  busWidthT ctrlWidth;

  xipseq_ctrl #(
    .ADDR_W(ADDR_W), .DUMMY_CYC(DUMMY_CYC), .RESCUE_LEN(RESCUE_LEN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .dq0(dqIn[0]),
    .cfgVolXipN(cfgVolXipN), .cfgAlwaysArm(cfgAlwaysArm), .cfgNvXip(cfgNvXip),
    .strobe(strobe), .xipActive(xipActive), .xipWidth(ctrlWidth)
  );

  xipseq_dpath #(.ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .dqIn(dqIn), .strobe(strobe), .rdData(rdData),
    .rdAddr(rdAddr), .dqOut(dqOut), .dqOe(dqOe)
  );

  assign xipWidth = ctrlWidth;

endmodule

// File: rtl/xip_frame_seq_chk.sv
module xip_frame_seq_chk #(
  parameter int RESCUE_LEN = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [3:0] dqIn,
  input logic [3:0] dqOe,
  input logic       xipActive
);

  localparam int RUN_W = $clog2(RESCUE_LEN + 1);

  logic [RUN_W-1:0] onesRun;
  logic             onesLive;

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      onesRun  <= '0;
      onesLive <= 1'b1;
    end else if (onesLive) begin
      if (dqIn[0]) onesRun <= onesRun + 1'b1;
      else         onesLive <= 1'b0;
    end
  end

  // R5
  oe_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe == 4'b0000 || dqOe == 4'b0010 || dqOe == 4'b0011 || dqOe == 4'b1111);

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> dqOe == 4'b0000);

  // R12
  xip_frame_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(xipActive) |-> !$past(csN));

  // R10
  rescue_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && onesLive && dqIn[0] && onesRun == RUN_W'(RESCUE_LEN - 1)) |=> !xipActive);

endmodule

bind xip_frame_seq xip_frame_seq_chk #(.RESCUE_LEN(RESCUE_LEN)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dqIn(dqIn), .dqOe(dqOe), .xipActive(xipActive)
);

// File: tb/xip_frame_seq_test.sv
`timescale 1ns/1ps
module xip_frame_seq_test;

  localparam int DUMMY = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic [3:0]  dqIn = 4'b0;
  logic [3:0]  dqOut, dqOe;
  logic        cfgVolXipN = 1'b1;
  logic        cfgAlwaysArm = 1'b0;
  logic [2:0]  cfgNvXip = 3'd7;
  logic [23:0] rdAddr;
  logic [7:0]  rdData;
  logic        xipActive;
  logic [1:0]  xipWidth;

  int nChk = 0;
  int nBad = 0;
  bit mXip;
  int mW;

  always #4 clk = ~clk;

  xip_frame_seq uut (
    .clk(clk), .rstN(rstN), .csN(csN), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .cfgVolXipN(cfgVolXipN), .cfgAlwaysArm(cfgAlwaysArm), .cfgNvXip(cfgNvXip),
    .rdAddr(rdAddr), .rdData(rdData), .xipActive(xipActive), .xipWidth(xipWidth)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hA5;
  endfunction

  assign rdData = memByte(rdAddr);

  function automatic logic [7:0] opcOf(input int w);
    return (w == 0) ? 8'h0B : (w == 1) ? 8'hBB : 8'hEB;
  endfunction

  function automatic logic [3:0] addrChunk(input logic [23:0] a, input int w, input int k);
    int bp = 1 << w;
    return 4'((a >> (24 - bp * (k + 1))) & ((1 << bp) - 1));
  endfunction

  function automatic logic [3:0] expChunk(input logic [7:0] b, input int w, input int j);
    int bp = 1 << w;
    logic [3:0] v = 4'((b >> (8 - bp * (j + 1))) & ((1 << bp) - 1));
    return (w == 0) ? {v[2:0], 1'b0} : v;
  endfunction

  function automatic logic [3:0] oeOf(input int w);
    return (w == 0) ? 4'b0010 : (w == 1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk1(input logic [3:0] d);
    @(negedge clk);
    csN = 1'b0;
    dqIn = d;
  endtask

  task automatic endFrame();
    logic held;
    @(negedge clk);
    csN = 1'b1;
    dqIn = 4'b0;
    @(negedge clk);
    check("R5 oe off after CS high", dqOe, 4'b0);
    held = xipActive;
    repeat (2) @(negedge clk);
    check("R12 xip held while CS high", xipActive, held);
  endtask

  task automatic doReset(input logic [2:0] nv);
    @(negedge clk);
    rstN = 1'b0;
    csN = 1'b1;
    cfgNvXip = nv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mXip = (nv < 3'd3);
    mW = mXip ? int'(nv) : 0;
    check("R1 xipActive after reset", xipActive, mXip);
    if (mXip) check("R1 xipWidth after reset", xipWidth, mW);
    check("R5 oe in reset state", dqOe, 4'b0);
  endtask

  task automatic readFrame(input int w, input logic [23:0] a, input bit conf,
                           input int nb, input string tag);
    int ew = mXip ? mW : w;
    int bp = 1 << ew;
    bit armed = mXip || !cfgVolXipN || cfgAlwaysArm;
    logic [7:0] op = opcOf(w);
    if (!mXip)
      for (int i = 0; i < 8; i++) clk1({3'b0, op[7-i]});
    for (int k = 0; k < 24 / bp; k++) clk1(addrChunk(a, ew, k));
    for (int d = 0; d < DUMMY; d++) clk1({3'b0, (d == 0) ? conf : 1'b0});
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < 8 / bp; j++) begin
        clk1(4'b0);
        check(tag, dqOut, expChunk(memByte(a + 24'(b)), ew, j));
        check("R5 oe in data", dqOe, oeOf(ew));
      end
    endFrame();
    if (conf) begin
      mXip = 0;
      check("R7 confirm 1 leaves XIP", xipActive, 0);
    end else if (armed) begin
      mXip = 1;
      mW = ew;
      check("R6 confirm 0 armed", xipActive, 1);
      check("R6 width latched", xipWidth, mW);
    end else begin
      check("R8 confirm 0 unarmed", xipActive, 0);
    end
  endtask

  task automatic abortFrame(input int w, input logic [23:0] a, input int k);
    int ew = mXip ? mW : w;
    logic [7:0] op = opcOf(w);
    if (!mXip)
      for (int i = 0; i < 8; i++) clk1({3'b0, op[7-i]});
    for (int c = 0; c < k; c++) clk1(addrChunk(a, ew, c));
    endFrame();
    check("R11 abort keeps xip", xipActive, mXip);
    if (mXip) check("R11 abort keeps width", xipWidth, mW);
  endtask

  task automatic rescueFrame();
    for (int i = 0; i < 8; i++) clk1(4'b0001);
    for (int i = 0; i < 20; i++) begin
      clk1(4'(i));
      check("R10 frame ignored after rescue", dqOe, 4'b0);
    end
    endFrame();
    mXip = 0;
    check("R10 rescue leaves XIP", xipActive, 0);
  endtask

  task automatic badOpcFrame(input logic [7:0] op);
    for (int i = 0; i < 8; i++) clk1({3'b0, op[7-i]});
    for (int i = 0; i < 40; i++) begin
      clk1(4'($urandom));
      check("R3 unknown opcode ignored", dqOe, 4'b0);
    end
    endFrame();
    check("R3 xip unchanged", xipActive, mXip);
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset(3'd7);
    // R2 standard single read, then leave
    readFrame(0, 24'h012345, 1'b1, 2, "R2 R4 single read");
    // R8 confirm 0 without arming
    readFrame(1, 24'h0ABCDE, 1'b0, 2, "R2 R4 dual read");
    // R6 arm through volatile bit
    cfgVolXipN = 1'b0;
    readFrame(1, 24'h054321, 1'b0, 2, "R2 R4 dual read armed");
    cfgVolXipN = 1'b1;
    readFrame(2, 24'h0FFFF0, 1'b0, 3, "R9 addr-only frame");
    // R11 abort mid-address, XIP stays
    abortFrame(0, 24'h011111, 5);
    readFrame(0, 24'h022222, 1'b0, 1, "R9 frame after abort");
    // R10 rescue
    rescueFrame();
    // R3 unknown opcode in standard mode
    badOpcFrame(8'h9F);
    // R6 strap arming, quad, then R7 exit from XIP frame
    cfgAlwaysArm = 1'b1;
    readFrame(2, 24'h00FF00, 1'b0, 2, "R2 R4 quad read");
    readFrame(0, 24'h0FFFFF, 1'b1, 2, "R9 quad xip wrap");
    cfgAlwaysArm = 1'b0;
    abortFrame(2, 24'h033333, 3);
    // R1 boot into dual and quad XIP
    doReset(3'd1);
    readFrame(0, 24'h0CAFE1, 1'b0, 2, "R1 R9 boot dual xip");
    doReset(3'd2);
    readFrame(0, 24'h0BEEF2, 1'b1, 1, "R1 R9 boot quad xip");
    doReset(3'd0);
    readFrame(2, 24'h012121, 1'b0, 1, "R1 R9 boot single xip");
    rescueFrame();
    doReset(3'd5);
    // random traffic
    for (int n = 0; n < 60; n++) begin
      int w = int'($urandom % 3);
      logic [23:0] a = {4'h0, 20'($urandom)};
      cfgVolXipN = 1'($urandom);
      cfgAlwaysArm = ($urandom % 4) == 0;
      if ($urandom % 8 == 0) abortFrame(w, a, 1 + int'($urandom % 5));
      else if ($urandom % 12 == 0) rescueFrame();
      else readFrame(w, a, ($urandom % 3) == 0, 1 + int'($urandom % 3),
                     mXip ? "R9 random xip" : "R4 random read");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule